// File: doc/BRIEF.md
# Windowed Gate Discriminator

This block decides in advance whether a later burst of serial data may pass. A timing strobe marks one instant. If a qualifier bit is high at that instant, the block arms. The arm decision waits until the next window opens, which is the first cycle of a run of high window-enable cycles. At that cycle the decision moves to the output stage and the arm flag clears.

The output stage then holds a pass signal high for every cycle of that window. Pass trails the window-enable input by two clock cycles. A per-lane valve lets the data lanes through only while pass is high.

Arming and output are decoupled. A coincidence that arrives while a window is open arms the following window and leaves the current one untouched. The strobes come from an external timing source.

Top module: `win_gate_disc`

## Requirements
- R1: The arm flag sets in the cycle after `strobe_i` and `qual_i` are both high. A strobe alone, or a qualifier alone, never arms the block.
- R2: Once set, the arm flag stays set until the next window start, however many idle cycles pass.
- R3: A window start is a cycle with `win_i` high whose previous cycle had `win_i` low. The arm state used is the one registered before that cycle. A coincidence during the start cycle itself arms only the following window. A window that stays high does not start again.
- R4: A window start clears the arm flag, unless a new coincidence arrives in that same cycle. One coincidence therefore grants exactly one window.
- R5: If the block was armed at a window start in cycle k, and the window's last high cycle is e, then `pass_o` is 1 in cycles k+2 through e+2 and 0 immediately after.
- R6: A window that starts while the block is unarmed gives `pass_o` = 0 for its whole length.
- R7: A coincidence inside an open window does not change `pass_o` for that window.
- R8: Each bit of `data_o` equals the same bit of `data_i` AND `pass_o`, with no register in that path.
- R9: While `rst_ni` is low, the arm flag, the window history and `pass_o` are cleared, and `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Timing strobe that marks the sampling instant |
| qual_i | input | 1 | Qualifier bit, sampled together with the strobe |
| win_i | input | 1 | Window-enable; a rising run defines one window |
| data_i | input | DATA_W | Serial data lanes |
| pass_o | output | 1 | Window pass, lagging `win_i` by two cycles |
| data_o | output | DATA_W | Gated data lanes |

## Verification
A stuck or lost arm flag only shows up at the next window start. It appears at the ports two cycles after that start, as a missing or spurious `pass_o` run. The bench therefore places coincidences before windows, inside windows and on the start cycle itself, and compares `pass_o` every cycle. A wrong window history shows up as a pass run that is shifted, cut short or restarted inside a long window. Each of these is visible within three cycles of the affected edge of `win_i`.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
  localparam int unsigned WGD_DATA_W_DEF = 8;

  // arm flag next-state selection
  typedef enum logic [1:0] {
    ARM_KEEP  = 2'd0,
    ARM_SET   = 2'd1,
    ARM_CLEAR = 2'd2
  } arm_op_e;
endpackage

// File: rtl/wgd_arm.sv
module wgd_arm
  import wgd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  input  logic qual_i,
  input  logic start_i,
  output logic arm_o
);
  arm_op_e op;
  logic    arm_q;

  // a fresh coincidence wins over a transfer: it belongs to the next window
  always_comb begin
    if (strobe_i && qual_i) op = ARM_SET;
    else if (start_i)       op = ARM_CLEAR;
    else                    op = ARM_KEEP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
    end else begin
      unique case (op)
        ARM_SET:   arm_q <= 1'b1;
        ARM_CLEAR: arm_q <= 1'b0;
        default:   arm_q <= arm_q;
      endcase
    end
  end

  assign arm_o = arm_q;
endmodule

// File: rtl/wgd_window.sv
module wgd_window (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_i,
  input  logic arm_i,
  output logic start_o,
  output logic pass_o
);
  logic win_q;
  logic grant_q;
  logic pass_q;

  assign start_o = win_i && !win_q;

  // stage 1: window history and granted decision for the open window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      win_q <= win_i;
      if (start_o)     grant_q <= arm_i;
      else if (!win_i) grant_q <= 1'b0;
    end
  end

  // stage 2: output register, two cycles behind win_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pass_q <= 1'b0;
    else         pass_q <= win_q && grant_q;
  end

  assign pass_o = pass_q;
endmodule

// File: rtl/wgd_valve.sv
module wgd_valve #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              pass_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_lane
    assign data_o[g] = data_i[g] & pass_i;
  end
endmodule

// File: rtl/win_gate_disc.sv
module win_gate_disc
  import wgd_pkg::*;
#(
  parameter int unsigned DATA_W = WGD_DATA_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              qual_i,
  input  logic              win_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pass_o,
  output logic [DATA_W-1:0] data_o
);
  logic arm_w;
  logic start_w;

  wgd_arm i_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .qual_i   (qual_i),
    .start_i  (start_w),
    .arm_o    (arm_w)
  );

  wgd_window i_window (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .win_i   (win_i),
    .arm_i   (arm_w),
    .start_o (start_w),
    .pass_o  (pass_o)
  );

  wgd_valve #(.DATA_W(DATA_W)) i_valve (
    .pass_i (pass_o),
    .data_i (data_i),
    .data_o (data_o)
  );
endmodule

// File: rtl/wgd_chk.sv
module wgd_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic              qual_i,
  input logic              win_i,
  input logic [DATA_W-1:0] data_i,
  input logic              pass_o,
  input logic [DATA_W-1:0] data_o,
  input logic              arm,
  input logic              start
);
  // R1
  arm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && qual_i) |=> arm);

  // R1
  arm_no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm && !(strobe_i && qual_i)) |=> !arm);

  // R2
  arm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm && !start) |=> arm);

  // R4
  arm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !(strobe_i && qual_i)) |=> !arm);

  // R5
  pass_lag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> $past(win_i, 2));

  // R5
  pass_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && arm) |=> ##1 pass_o);

  // R6
  unarmed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && !arm) |=> ##1 !pass_o);

  // R8
  valve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pass_o |-> (data_o == '0));
endmodule

bind win_gate_disc wgd_chk #(.DATA_W(DATA_W)) i_wgd_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_i (strobe_i),
  .qual_i   (qual_i),
  .win_i    (win_i),
  .data_i   (data_i),
  .pass_o   (pass_o),
  .data_o   (data_o),
  .arm      (arm_w),
  .start    (start_w)
);

// File: tb/test_win_gate_disc.sv
module test_win_gate_disc;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          strobe = 1'b0;
  logic          qual = 1'b0;
  logic          win = 1'b0;
  logic [DW-1:0] data = '0;
  logic          pass_o;
  logic [DW-1:0] data_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state, derived from the requirements
  logic m_arm = 1'b0, m_wprev = 1'b0, m_g1 = 1'b0, m_exp = 1'b0;

  always #5 clk = ~clk;

  win_gate_disc #(.DATA_W(DW)) i_win_gate_disc (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_i(strobe), .qual_i(qual),
    .win_i(win), .data_i(data), .pass_o(pass_o), .data_o(data_o)
  );

  function automatic logic [DW-1:0] gated(input logic [DW-1:0] d, input logic p);
    return p ? d : '0;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic s, input logic t, input logic w,
                      input logic [DW-1:0] d, input string tag);
    logic rise, g_n;
    @(negedge clk);
    qual = s; strobe = t; win = w; data = d;
    #1;
    check({tag, " pass"}, {{(DW-1){1'b0}}, pass_o}, {{(DW-1){1'b0}}, m_exp});
    check("R8 valve", data_o, gated(d, m_exp));
    rise   = w && !m_wprev;
    g_n    = w ? (rise ? m_arm : m_g1) : 1'b0;
    m_exp  = m_g1;
    m_g1   = g_n;
    m_arm  = (s && t) || (m_arm && !rise);
    m_wprev = w;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; strobe = 1'b0; qual = 1'b0; win = 1'b0; data = '1;
    #1;
    check("R9 reset pass", {{(DW-1){1'b0}}, pass_o}, '0);
    check("R9 reset data", data_o, '0);
    m_arm = 0; m_wprev = 0; m_g1 = 0; m_exp = 0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, DW'($urandom), tag);
  endtask

  task automatic window(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 1, DW'($urandom), tag);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    do_reset();

    // R1: strobe or qualifier alone does not arm; R6: unarmed window silent
    step(1, 0, 0, '1, "R1");
    step(0, 1, 0, '1, "R1");
    idle(2, "R1");
    window(4, "R6");
    idle(3, "R6");

    // R2 long hold, then R5 full window run
    step(1, 1, 0, '1, "R2");
    idle(10, "R2");
    window(5, "R5");
    idle(4, "R5");

    // R7: coincidence inside an armed window; R4: next window granted once
    step(1, 1, 0, '1, "R7");
    idle(1, "R7");
    window(2, "R7");
    step(1, 1, 1, '1, "R7");
    window(3, "R7");
    idle(3, "R4");
    window(3, "R4");
    idle(3, "R4");
    window(3, "R4");
    idle(3, "R4");

    // R3: coincidence on the start cycle counts only for the next window
    step(1, 1, 1, '1, "R3");
    window(3, "R3");
    idle(2, "R3");
    window(3, "R3");
    idle(3, "R3");
    // R3: long window does not restart after a mid-window coincidence
    window(2, "R3");
    step(1, 1, 1, '1, "R3");
    window(6, "R3");
    idle(3, "R3");

    // R9: reset in the middle of an armed window
    step(1, 1, 0, '1, "R9");
    idle(1, "R9");
    window(3, "R9");
    do_reset();
    idle(2, "R9");
    window(3, "R9");
    idle(3, "R9");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic s, t, w;
      s = ($urandom % 4) == 0;
      t = ($urandom % 3) == 0;
      w = ($urandom % 8) < 5 ? m_wprev : ~m_wprev;
      step(s, t, w, DW'($urandom), "R5 rnd");
    end
    idle(4, "R5 rnd");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule